// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

This block holds two 8-bit up-counters. Each counter has a control register that picks where its count enables come from and what clears it. Each counter also has two compare registers, named A and B, and a set of sticky event flags. A counter can advance on one of three taps of a shared prescaler. It can advance on edges of an external clock pin, where the rising, falling or both edges can be chosen. It can also advance on events from the other channel, so that the two channels form a 16-bit or event-counting chain. A counter can be cleared by a match on compare A, by a match on compare B, or by a rising edge on an external reset pin.

Everything runs on the one system clock. The external pins are synchronised and edge-detected, and every count source reaches the counter as a one-cycle enable. Software-style access is a plain write port and a registered read port. Each port selects a channel and a register address.

Register addresses (per channel): 0 = control, 1 = flags, 2 = counter, 3 = compare A, 4 = compare B. Other addresses read as zero.

Top module: `tmr_pair`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x00, the flags read 0x00, and both compare registers read 0xFF. A read returns the addressed register one clock after the address is presented.
- R2: The control register holds the clock source in bits [2:0] and the clear source in bits [4:3]. Clock source 000 stops the counter: no external pin activity changes it.
- R3: Clock sources 001, 010 and 011 advance the counter once every 8, 64 and 8192 system clocks. The prescaler runs freely from reset, and the counter steps when the prescaler tap falls.
- R4: Clock sources 101, 110 and 111 count rising, falling, and both edges of the external clock pin.
- R5: Clock source 100 cascades the channels. Channel 1 advances once for each compare-A match of channel 0, and channel 0 advances once for each overflow of channel 1.
- R6: When both channels select clock source 100 at once, no cascade enable reaches either counter.
- R7: Clear source 01 returns the counter to 0x00 on the cycle after it becomes equal to compare A. After N enables from zero, the counter holds N mod A.
- R8: Clear source 10 does the same with compare B.
- R9: Clear source 11 clears the counter on a rising edge of the external reset pin. Under clear source 00, that pin has no effect.
- R10: When an enable meets a counter at 0xFF, the counter wraps to 0x00 and sets flag bit 2 (overflow). The flag stays set.
- R11: Flag bit 0 is set when the counter becomes equal to compare A, and flag bit 1 when it becomes equal to compare B.
- R12: A write to address 1 ANDs the flags with the written data. Writing 0 clears a flag, and writing 1 leaves it unchanged.
- R13: When a clear and a count enable fall in the same cycle, the counter becomes 0x00. A write to the counter overrides both the count and the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| ext_rst_i | input | 1 | External clear pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 1 | Channel selected for the write |
| wr_addr_i | input | 3 | Register address for the write |
| wr_data_i | input | 8 | Write data |
| rd_ch_i | input | 1 | Channel selected for the read |
| rd_addr_i | input | 3 | Register address for the read |
| rd_data_o | output | 8 | Registered read data |

## Verification
The assertions assume that the external pins are held stable for several system clocks, so that every level change survives the two-stage synchroniser and yields exactly one edge event. They also assume that a compare register is not rewritten to the current count while a clear-on-match is intended. The stimulus holds each external pin level for four clocks. It sets the compare values and counters before it selects a count source. Rate checks measure the counter across a window that is a whole multiple of the tap period, so the free-running prescaler phase does not affect the expected difference.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    CK_STOP     = 3'd0,
    CK_DIV_A    = 3'd1,
    CK_DIV_B    = 3'd2,
    CK_DIV_C    = 3'd3,
    CK_CHAIN    = 3'd4,
    CK_EXT_RISE = 3'd5,
    CK_EXT_FALL = 3'd6,
    CK_EXT_BOTH = 3'd7
  } clk_src_e;

  typedef enum logic [1:0] {
    CLR_OFF     = 2'd0,
    CLR_MATCH_A = 2'd1,
    CLR_MATCH_B = 2'd2,
    CLR_PIN     = 2'd3
  } clr_src_e;

  localparam int ADDR_W      = 3;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_FLAGS = 3'd1;
  localparam logic [ADDR_W-1:0] RA_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMP_A = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CMP_B = 3'd4;

  localparam int NUM_TAPS = 3;
  localparam int FLAG_W   = 3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRESC_W = 13,
  parameter int TAP0    = 2,
  parameter int TAP1    = 5,
  parameter int TAP2    = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [tmr_pkg::NUM_TAPS-1:0]  tick_o
);
  localparam int NT = tmr_pkg::NUM_TAPS;

  logic [PRESC_W-1:0] div_q;
  logic [NT-1:0]      tap_prev_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_tap
    localparam int TB = (g == 0) ? TAP0 : (g == 1) ? TAP1 : TAP2;

    always_ff @(posedge clk) begin
      if (rst) tap_prev_q[g] <= 1'b0;
      else     tap_prev_q[g] <= div_q[TB];
    end

    assign tick_o[g] = tap_prev_q[g] & ~div_q[TB];

    p_tick_aligned_r3: assert property (@(posedge clk) disable iff (rst)
      tick_o[g] |-> (div_q[TB:0] == '0));
  end

endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

  p_single_edge_r4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TAPS-1:0]  tick_i,
  input  logic                 ext_rise_i,
  input  logic                 ext_fall_i,
  input  logic                 pin_clr_i,
  input  logic                 chain_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [CNT_W-1:0]     rd_val_o,
  output clk_src_e             src_o,
  output logic                 step_o,
  output logic                 ovf_pulse_o,
  output logic                 cma_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  clk_src_e           src_q;
  clr_src_e           clr_q;
  logic [CNT_W-1:0]   cnt_q, cmp_a_q, cmp_b_q;
  logic [FLAG_W-1:0]  flags_q;
  logic               eq_a_q, eq_b_q;
  logic               eq_a, eq_b, hit_a, hit_b;
  logic               step, clr_evt, wr_cnt, wrap;

  assign wr_cnt = wr_en_i && (wr_addr_i == RA_COUNT);

  always_comb begin
    unique case (src_q)
      CK_DIV_A:    step = tick_i[0];
      CK_DIV_B:    step = tick_i[1];
      CK_DIV_C:    step = tick_i[2];
      CK_CHAIN:    step = chain_i;
      CK_EXT_RISE: step = ext_rise_i;
      CK_EXT_FALL: step = ext_fall_i;
      CK_EXT_BOTH: step = ext_rise_i | ext_fall_i;
      default:     step = 1'b0;
    endcase
  end

  assign eq_a  = (cnt_q == cmp_a_q);
  assign eq_b  = (cnt_q == cmp_b_q);
  assign hit_a = eq_a & ~eq_a_q;
  assign hit_b = eq_b & ~eq_b_q;

  always_comb begin
    unique case (clr_q)
      CLR_MATCH_A: clr_evt = hit_a;
      CLR_MATCH_B: clr_evt = hit_b;
      CLR_PIN:     clr_evt = pin_clr_i;
      default:     clr_evt = 1'b0;
    endcase
  end

  assign wrap = step && (cnt_q == CNT_MAX) && !clr_evt && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= CK_STOP;
      clr_q   <= CLR_OFF;
      cmp_a_q <= '1;
      cmp_b_q <= '1;
    end else if (wr_en_i) begin
      if (wr_addr_i == RA_CTRL) begin
        src_q <= clk_src_e'(wr_data_i[2:0]);
        clr_q <= clr_src_e'(wr_data_i[4:3]);
      end
      if (wr_addr_i == RA_CMP_A) cmp_a_q <= wr_data_i;
      if (wr_addr_i == RA_CMP_B) cmp_b_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wr_data_i;
    else if (clr_evt) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_a_q      <= 1'b0;
      eq_b_q      <= 1'b0;
      flags_q     <= '0;
      ovf_pulse_o <= 1'b0;
      cma_pulse_o <= 1'b0;
    end else begin
      eq_a_q      <= eq_a;
      eq_b_q      <= eq_b;
      ovf_pulse_o <= wrap;
      cma_pulse_o <= hit_a;
      if (wr_en_i && wr_addr_i == RA_FLAGS)
        flags_q <= (flags_q & wr_data_i[FLAG_W-1:0]) | {wrap, hit_b, hit_a};
      else
        flags_q <= flags_q | {wrap, hit_b, hit_a};
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      RA_CTRL:  rd_val_o = CNT_W'({clr_q, src_q});
      RA_FLAGS: rd_val_o = CNT_W'(flags_q);
      RA_COUNT: rd_val_o = cnt_q;
      RA_CMP_A: rd_val_o = cmp_a_q;
      RA_CMP_B: rd_val_o = cmp_b_q;
      default:  rd_val_o = '0;
    endcase
  end

  assign src_o  = src_q;
  assign step_o = step;

  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (src_q == CK_STOP && !wr_cnt && !clr_evt) |=> $stable(cnt_q));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !clr_evt && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_flag_r10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (flags_q[2] && cnt_q == '0));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flags_q[2] && !(wr_en_i && wr_addr_i == RA_FLAGS)) |=> flags_q[2]);

  p_clear_wins_r13: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !wr_cnt) |=> (cnt_q == '0));

  p_write_wins_r13: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wr_data_i)));

  p_match_a_flag_r11: assert property (@(posedge clk) disable iff (rst)
    hit_a |=> flags_q[0]);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRESC_W     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_i,
  input  logic              ext_rst_i,
  input  logic              wr_en_i,
  input  logic              wr_ch_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              rd_ch_i,
  input  logic [2:0]        rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  localparam int NCH = 2;

  logic [NUM_TAPS-1:0] tick;
  logic                ck_rise, ck_fall, pin_rise, pin_fall_unused;
  logic                chain_block;
  logic [NCH-1:0]      chain_in, step, ovf_p, cma_p;
  clk_src_e            src [NCH];
  logic [CNT_W-1:0]    rd_val [NCH];

  tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick));

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .pin_i(ext_clk_i), .rise_o(ck_rise), .fall_o(ck_fall));

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_rst (
    .clk(clk), .rst(rst), .pin_i(ext_rst_i), .rise_o(pin_rise), .fall_o(pin_fall_unused));

  assign chain_block = (src[0] == CK_CHAIN) && (src[1] == CK_CHAIN);
  assign chain_in[0] = ovf_p[1] & ~chain_block;
  assign chain_in[1] = cma_p[0] & ~chain_block;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .tick_i(tick),
      .ext_rise_i(ck_rise), .ext_fall_i(ck_fall),
      .pin_clr_i(pin_rise),
      .chain_i(chain_in[c]),
      .wr_en_i(wr_en_i && (wr_ch_i == c[0])),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_val_o(rd_val[c]),
      .src_o(src[c]), .step_o(step[c]),
      .ovf_pulse_o(ovf_p[c]), .cma_pulse_o(cma_p[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_ch_i ? rd_val[1] : rd_val[0];
  end

  p_chain_lock_r6: assert property (@(posedge clk) disable iff (rst)
    chain_block |-> (step == '0));

  p_chain_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_p[1] && src[0] == CK_CHAIN && src[1] != CK_CHAIN) |-> step[0]);

endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0, ext_rst = 1'b0;
  logic       wr_en = 1'b0, wr_ch = 1'b0, rd_ch = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk), .ext_rst_i(ext_rst),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_ch_i(rd_ch), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(bit ch, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(bit ch, logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_ch = ch; rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1; idle(3);
      @(negedge clk); ext_clk = 1'b0; idle(3);
    end
    idle(4);
  endtask

  // control byte: clear source in [4:3], clock source in [2:0]
  function automatic logic [7:0] ctl(logic [1:0] c, logic [2:0] s);
    return {3'b000, c, s};
  endfunction

  task automatic rate(logic [2:0] s, int period, int k, string req);
    logic [7:0] a, b;
    wr(0, 3'd0, ctl(2'd0, s));
    wr(0, 3'd2, 8'h00);
    rd(0, 3'd2, a);
    idle(period * k - 1);
    rd(0, 3'd2, b);
    chk(req, b - a, 8'(k));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    rd(0, 3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(0, 3'd2, v); chk("R1 count", v, 8'h00);
    rd(1, 3'd1, v); chk("R1 flags", v, 8'h00);
    rd(0, 3'd3, v); chk("R1 cmpA", v, 8'hFF);
    rd(1, 3'd4, v); chk("R1 cmpB", v, 8'hFF);

    // R2 stopped source ignores pin edges
    wr(0, 3'd2, 8'h33);
    pulses(3);
    rd(0, 3'd2, v); chk("R2 stop", v, 8'h33);

    // R3 prescaler rates
    rate(3'd1, 8, 5, "R3 div8");
    rate(3'd2, 64, 3, "R3 div64");
    rate(3'd3, 8192, 2, "R3 div8192");

    // R4 external edges
    for (int m = 0; m < 3; m++) begin
      wr(0, 3'd0, ctl(2'd0, 3'(5 + m)));
      wr(0, 3'd2, 8'h00);
      pulses(6);
      rd(0, 3'd2, v);
      chk("R4 ext edges", v, (m == 2) ? 8'd12 : 8'd6);
    end

    // R7 + R5: ch0 clears on A=3, ch1 counts ch0 A matches
    wr(0, 3'd0, 8'h00);
    wr(0, 3'd3, 8'd3);
    wr(0, 3'd2, 8'h00);
    wr(1, 3'd2, 8'h00);
    wr(1, 3'd0, ctl(2'd0, 3'd4));
    wr(0, 3'd0, ctl(2'd1, 3'd5));
    pulses(10);
    rd(0, 3'd2, v); chk("R7 N mod A", v, 8'd1);
    rd(1, 3'd2, v); chk("R5 ch1 counts A matches", v, 8'd3);
    rd(0, 3'd1, v); chk("R11 flagA set", v & 8'h01, 8'h01);

    // R5 + R10: ch0 counts ch1 overflow
    wr(1, 3'd0, 8'h00);
    wr(0, 3'd0, 8'h00);
    wr(1, 3'd3, 8'h10);
    wr(1, 3'd4, 8'h10);
    wr(1, 3'd1, 8'h00);
    wr(1, 3'd2, 8'hFE);
    wr(0, 3'd2, 8'h00);
    wr(1, 3'd0, ctl(2'd0, 3'd5));
    wr(0, 3'd0, ctl(2'd0, 3'd4));
    pulses(2);
    rd(1, 3'd2, v); chk("R10 wrap", v, 8'h00);
    rd(0, 3'd2, v); chk("R5 ch0 counts overflow", v, 8'h01);
    idle(20);
    rd(1, 3'd1, v); chk("R10 ovf sticky", v, 8'h04);

    // R12 flag write semantics
    wr(1, 3'd1, 8'hFF);
    rd(1, 3'd1, v); chk("R12 write one keeps", v, 8'h04);
    wr(1, 3'd1, 8'h00);
    rd(1, 3'd1, v); chk("R12 write zero clears", v, 8'h00);

    // R6 both chained: ch0 A match must not reach ch1
    wr(1, 3'd0, 8'h00);
    wr(0, 3'd0, 8'h00);
    wr(1, 3'd2, 8'h20);
    wr(0, 3'd3, 8'd3);
    wr(0, 3'd2, 8'h00);
    wr(0, 3'd1, 8'h00);
    wr(0, 3'd0, ctl(2'd0, 3'd4));
    wr(1, 3'd0, ctl(2'd0, 3'd4));
    wr(0, 3'd2, 8'd3);
    idle(5);
    rd(1, 3'd2, v); chk("R6 no chain count", v, 8'h20);
    rd(0, 3'd1, v); chk("R11 flagA on write match", v, 8'h01);

    // R8 + R11: clear on B=5
    wr(1, 3'd0, 8'h00);
    wr(0, 3'd0, 8'h00);
    wr(0, 3'd3, 8'hFF);
    wr(0, 3'd4, 8'd5);
    wr(0, 3'd2, 8'h00);
    wr(0, 3'd1, 8'h00);
    wr(0, 3'd0, ctl(2'd2, 3'd5));
    pulses(7);
    rd(0, 3'd2, v); chk("R8 N mod B", v, 8'd2);
    rd(0, 3'd1, v); chk("R11 flagB only", v, 8'h02);

    // R9 pin clear ignored under clear source 00
    wr(0, 3'd0, 8'h00);
    wr(0, 3'd2, 8'd9);
    @(negedge clk) ext_rst = 1'b1; idle(4);
    @(negedge clk) ext_rst = 1'b0; idle(4);
    rd(0, 3'd2, v); chk("R9 pin ignored", v, 8'd9);

    // R9 pin clear active
    wr(0, 3'd0, ctl(2'd3, 3'd0));
    @(negedge clk) ext_rst = 1'b1; idle(4);
    @(negedge clk) ext_rst = 1'b0; idle(4);
    rd(0, 3'd2, v); chk("R9 pin clears", v, 8'd0);

    // R13 clear beats count in the same cycle
    wr(0, 3'd0, ctl(2'd3, 3'd5));
    wr(0, 3'd2, 8'd5);
    @(negedge clk) begin ext_clk = 1'b1; ext_rst = 1'b1; end
    idle(4);
    @(negedge clk) begin ext_clk = 1'b0; ext_rst = 1'b0; end
    idle(4);
    rd(0, 3'd2, v); chk("R13 clear over count", v, 8'd0);

    // R13 write beats count in the same cycle
    wr(0, 3'd0, ctl(2'd0, 3'd5));
    wr(0, 3'd2, 8'd10);
    @(negedge clk) ext_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 1'b0; wr_addr = 3'd2; wr_data = 8'h40;
    @(negedge clk) wr_en = 1'b0;
    idle(3);
    @(negedge clk) ext_clk = 1'b0;
    idle(4);
    rd(0, 3'd2, v); chk("R13 write over count", v, 8'h40);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule